// File: doc/BRIEF.md
# Power Wakeup Status Register

This block is one word of a low-power controller's register space. It reports why and how the device came back from its lowest power state. It keeps a software-controlled enable for a dedicated wakeup pin, a sticky wakeup flag, a sticky standby flag and a sampled copy of the supply-voltage monitor's comparator output. Software reaches it through a simple APB-style port. Writes finish at once. Reads stretch the transfer by a fixed number of wait cycles.

Hardware sets the wakeup flag in three cases: a synchronized rising edge on the wakeup pin while the pin is enabled, a pulse from the real-time-clock alarm, or software turning the enable on while the pin is already high. The standby-exit sequencer pulses an input that sets the standby flag. A companion control register supplies one-cycle clear strobes for the two flags. When a clear and a set arrive in the same cycle, the set wins.

The block has two reset inputs. The power-on reset clears everything. The system reset, which is also what a standby wakeup produces, clears only the pin enable and the bus wait counter, so both flags survive it.

Top module: `pwr_wake_csr`

## Requirements
- R1: Only address 0x04 selects the register. A read at any other address completes with no wait cycle and returns 0, and a write at any other address changes nothing.
- R2: The read word places the pin enable at bit 8, the monitor output at bit 2, the standby flag at bit 1 and the wakeup flag at bit 0. Every other bit reads 0.
- R3: Power-on reset clears all bits. System reset clears only bit 8; both flags keep their values through it.
- R4: A write to the register loads bit 8 from write data bit 8. Write data in any other bit position, including the three status bits, has no effect.
- R5: A write access completes with pready high in its first access cycle.
- R6: A read access to the register holds pready low for exactly two access cycles, and the data is returned in the third.
- R7: Bit 2 equals the comparator input, sampled one cycle earlier, while the monitor enable input is 1, and reads 0 while the monitor enable is 0.
- R8: With bit 8 set, a rising edge on the wakeup pin sets the wakeup flag after a two-flop synchronizer. With bit 8 clear, pin edges never set it.
- R9: A one-cycle alarm pulse sets the wakeup flag on the next clock edge.
- R10: A write that changes bit 8 from 0 to 1 while the synchronized pin is high sets the wakeup flag. Enabling while the pin is low does not.
- R11: A one-cycle standby-exit pulse sets the standby flag on the next clock edge.
- R12: A clear strobe clears its flag on the next edge, unless a set event for the same flag occurs in the same cycle, in which case the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears all state |
| sys_rst | input | 1 | System reset, synchronous, active high; clears enable and wait counter |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid when pready is high in a read access |
| pready | output | 1 | Transfer completes in this cycle |
| wake_pin | input | 1 | Asynchronous wakeup pin level |
| rtc_alarm | input | 1 | One-cycle alarm pulse from the real-time clock |
| stby_exit | input | 1 | One-cycle pulse: the device has left standby |
| vmon_en | input | 1 | Supply-voltage monitor enable |
| vmon_cmp | input | 1 | Supply-voltage comparator output |
| clr_wake | input | 1 | Clear strobe for the wakeup flag |
| clr_stby | input | 1 | Clear strobe for the standby flag |
| wake_pin_en | output | 1 | Current value of the pin enable, for the pin pad configuration |

## Verification
On every cycle the assertions check the bus timing: the read wait count, the zero-wait writes, the zero data and zero wait at foreign addresses, and reserved bits staying 0. They also check the single-cycle effects of alarm, standby-exit and clear pulses, the flags staying set when no clear strobe arrives, and the enable dropping after system reset. Other behaviours depend on a history of stimulus, and only the bench scenarios can show them. These are the synchronizer delay before a pin edge takes effect, the difference between enabling with the pin high and with it low, pin edges being ignored while disabled, set-over-clear in a shared cycle, and flags surviving a system reset but not a power-on reset.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int REG_OFS  = 4;
  localparam int RD_WAIT  = 2;
  localparam int SYNC_LEN = 2;

  // Bit positions decoded by software
  localparam int BIT_WAKE = 0;
  localparam int BIT_STBY = 1;
  localparam int BIT_VMON = 2;
  localparam int BIT_EN   = 8;

  // Sticky flag indices inside the flag bank
  localparam int FLG_WAKE = 0;
  localparam int FLG_STBY = 1;
  localparam int NUM_FLG  = 2;

  typedef struct packed {
    logic pin_en;
    logic vmon;
    logic stby;
    logic wake;
  } csr_view_t;

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[LAST];
  end

  assign level = chain_q[LAST];
  assign rise  = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/pwr_wake_flag.sv
module pwr_wake_flag #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk) begin
        if (rst)           f_q <= 1'b0;
        else if (set_i[g]) f_q <= 1'b1;   // set has priority over clear
        else if (clr_i[g]) f_q <= 1'b0;
      end
      assign flag_o[g] = f_q;
    end
  endgenerate

endmodule

// File: rtl/pwr_wake_bus.sv
module pwr_wake_bus #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int REG_OFS = 4,
  parameter int RD_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              wr_hit
);
  localparam int CNT_W = $clog2(RD_WAIT + 2);
  localparam logic [CNT_W-1:0]  WAIT_LIM = CNT_W'(RD_WAIT);
  localparam logic [ADDR_W-1:0] OFS      = ADDR_W'(REG_OFS);

  logic             hit;
  logic             rd_hit;
  logic             waiting;
  logic [CNT_W-1:0] cnt_q;

  assign hit     = (paddr == OFS);
  assign rd_hit  = psel & penable & ~pwrite & hit;
  assign waiting = rd_hit & (cnt_q != WAIT_LIM);
  assign wr_hit  = psel & penable & pwrite & hit;
  assign pready  = ~waiting;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (waiting) cnt_q <= cnt_q + 1'b1;
    else              cnt_q <= '0;
  end

  always_comb begin
    prdata = '0;
    if (rd_hit && !waiting) prdata = word_i;
  end

endmodule

// File: rtl/pwr_wake_csr.sv
module pwr_wake_csr
  import pwr_wake_pkg::*;
#(
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_DATA_W  = DATA_W,
  parameter int P_REG_OFS = REG_OFS,
  parameter int P_RD_WAIT = RD_WAIT,
  parameter int P_SYNC    = SYNC_LEN
) (
  input  logic                clk,
  input  logic                por_rst,
  input  logic                sys_rst,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [P_ADDR_W-1:0] paddr,
  input  logic [P_DATA_W-1:0] pwdata,
  output logic [P_DATA_W-1:0] prdata,
  output logic                pready,
  input  logic                wake_pin,
  input  logic                rtc_alarm,
  input  logic                stby_exit,
  input  logic                vmon_en,
  input  logic                vmon_cmp,
  input  logic                clr_wake,
  input  logic                clr_stby,
  output logic                wake_pin_en
);
  logic               any_rst;
  logic               en_q;
  logic               vmon_q;
  logic               pin_lvl;
  logic               pin_rise;
  logic               wr_hit;
  logic               en_rise_wr;
  logic [NUM_FLG-1:0] flg_set;
  logic [NUM_FLG-1:0] flg_clr;
  logic [NUM_FLG-1:0] flag_q;
  csr_view_t          view;
  logic [P_DATA_W-1:0] word;

  assign any_rst = por_rst | sys_rst;

  pwr_wake_sync #(.STAGES(P_SYNC)) u_sync (
    .clk      (clk),
    .rst      (por_rst),
    .async_in (wake_pin),
    .level    (pin_lvl),
    .rise     (pin_rise)
  );

  pwr_wake_bus #(
    .ADDR_W  (P_ADDR_W),
    .DATA_W  (P_DATA_W),
    .REG_OFS (P_REG_OFS),
    .RD_WAIT (P_RD_WAIT)
  ) u_bus (
    .clk     (clk),
    .rst     (any_rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .word_i  (word),
    .prdata  (prdata),
    .pready  (pready),
    .wr_hit  (wr_hit)
  );

  // Pin enable: cleared by either reset
  always_ff @(posedge clk) begin
    if (any_rst)     en_q <= 1'b0;
    else if (wr_hit) en_q <= pwdata[BIT_EN];
  end

  // Monitor output sample, forced low while monitor disabled
  always_ff @(posedge clk) begin
    if (any_rst) vmon_q <= 1'b0;
    else         vmon_q <= vmon_en & vmon_cmp;
  end

  // Old/new comparison of the enable in the write cycle
  assign en_rise_wr = wr_hit & pwdata[BIT_EN] & ~en_q;

  assign flg_set[FLG_WAKE] = (en_q & pin_rise) | (en_rise_wr & pin_lvl) | rtc_alarm;
  assign flg_set[FLG_STBY] = stby_exit;
  assign flg_clr[FLG_WAKE] = clr_wake;
  assign flg_clr[FLG_STBY] = clr_stby;

  pwr_wake_flag #(.N(NUM_FLG)) u_flags (
    .clk    (clk),
    .rst    (por_rst),
    .set_i  (flg_set),
    .clr_i  (flg_clr),
    .flag_o (flag_q)
  );

  assign view.pin_en = en_q;
  assign view.vmon   = vmon_q;
  assign view.stby   = flag_q[FLG_STBY];
  assign view.wake   = flag_q[FLG_WAKE];

  always_comb begin
    word           = '0;
    word[BIT_EN]   = view.pin_en;
    word[BIT_VMON] = view.vmon;
    word[BIT_STBY] = view.stby;
    word[BIT_WAKE] = view.wake;
  end

  assign wake_pin_en = en_q;

endmodule

// File: rtl/pwr_wake_csr_chk.sv
module pwr_wake_csr_chk
  import pwr_wake_pkg::*;
#(
  parameter int C_ADDR_W  = ADDR_W,
  parameter int C_DATA_W  = DATA_W,
  parameter int C_REG_OFS = REG_OFS,
  parameter int C_RD_WAIT = RD_WAIT
) (
  input logic                clk,
  input logic                por_rst,
  input logic                sys_rst,
  input logic                psel,
  input logic                penable,
  input logic                pwrite,
  input logic [C_ADDR_W-1:0] paddr,
  input logic [C_DATA_W-1:0] prdata,
  input logic                pready,
  input logic                rtc_alarm,
  input logic                stby_exit,
  input logic                vmon_en,
  input logic                clr_wake,
  input logic                clr_stby,
  input logic                wake_pin_en,
  input logic [NUM_FLG-1:0]  flag_q,
  input logic                vmon_q
);
  localparam logic [C_ADDR_W-1:0] OFS = C_ADDR_W'(C_REG_OFS);
  localparam logic [C_DATA_W-1:0] USED =
    (C_DATA_W'(1) << BIT_EN) | (C_DATA_W'(1) << BIT_VMON) |
    (C_DATA_W'(1) << BIT_STBY) | (C_DATA_W'(1) << BIT_WAKE);

  logic       rd_hit;
  logic [3:0] wcnt;

  assign rd_hit = psel & penable & ~pwrite & (paddr == OFS);

  always_ff @(posedge clk) begin
    if (por_rst || sys_rst)   wcnt <= '0;
    else if (rd_hit && !pready) wcnt <= wcnt + 1'b1;
    else                      wcnt <= '0;
  end

  a_r6_read_wait: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    rd_hit && pready |-> wcnt == 4'(C_RD_WAIT));

  a_r5_write_ready: assert property (@(posedge clk) disable iff (por_rst)
    psel && penable && pwrite |-> pready);

  a_r1_other_ofs: assert property (@(posedge clk) disable iff (por_rst)
    psel && penable && (paddr != OFS) |-> pready && (prdata == '0));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (por_rst)
    (prdata & ~USED) == '0);

  a_r3_sysrst_en: assert property (@(posedge clk) disable iff (por_rst)
    sys_rst |=> !wake_pin_en);

  a_r9_alarm_sets: assert property (@(posedge clk) disable iff (por_rst)
    rtc_alarm |=> flag_q[FLG_WAKE]);

  a_r11_stby_sets: assert property (@(posedge clk) disable iff (por_rst)
    stby_exit |=> flag_q[FLG_STBY]);

  a_r12_stby_clear: assert property (@(posedge clk) disable iff (por_rst)
    clr_stby && !stby_exit |=> !flag_q[FLG_STBY]);

  a_r12_wake_sticky: assert property (@(posedge clk) disable iff (por_rst)
    flag_q[FLG_WAKE] && !clr_wake |=> flag_q[FLG_WAKE]);

  a_r7_vmon_off: assert property (@(posedge clk) disable iff (por_rst)
    !vmon_en |=> !vmon_q);

endmodule

bind pwr_wake_csr pwr_wake_csr_chk #(
  .C_ADDR_W  (P_ADDR_W),
  .C_DATA_W  (P_DATA_W),
  .C_REG_OFS (P_REG_OFS),
  .C_RD_WAIT (P_RD_WAIT)
) u_chk (
  .clk         (clk),
  .por_rst     (por_rst),
  .sys_rst     (sys_rst),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .prdata      (prdata),
  .pready      (pready),
  .rtc_alarm   (rtc_alarm),
  .stby_exit   (stby_exit),
  .vmon_en     (vmon_en),
  .clr_wake    (clr_wake),
  .clr_stby    (clr_stby),
  .wake_pin_en (wake_pin_en),
  .flag_q      (flag_q),
  .vmon_q      (vmon_q)
);

// File: tb/sim_pwr_wake_csr.sv
`timescale 1ns/1ps
module sim_pwr_wake_csr;
  import pwr_wake_pkg::*;

  logic              clk = 1'b0;
  logic              por_rst = 1'b1, sys_rst = 1'b1;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [DATA_W-1:0] prdata;
  logic              pready;
  logic              wake_pin = 1'b0, rtc_alarm = 1'b0, stby_exit = 1'b0;
  logic              vmon_en = 1'b0, vmon_cmp = 1'b0;
  logic              clr_wake = 1'b0, clr_stby = 1'b0;
  logic              wake_pin_en;

  int checks = 0;
  int errors = 0;
  int wcnt   = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] exp_q[$];
  int                wait_q[$];
  string             tag_q[$];

  always #2 clk = ~clk;

  pwr_wake_csr u0 (
    .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .wake_pin(wake_pin), .rtc_alarm(rtc_alarm), .stby_exit(stby_exit),
    .vmon_en(vmon_en), .vmon_cmp(vmon_cmp),
    .clr_wake(clr_wake), .clr_stby(clr_stby), .wake_pin_en(wake_pin_en)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: counts wait cycles and pops expectations when a read completes
  initial begin
    forever begin
      @(negedge clk);
      if (psel && penable && !pwrite) begin
        if (!pready) wcnt++;
        else if (exp_q.size() == 0) begin
          check("monitor unexpected read", prdata, '0);
          wcnt = 0;
        end else begin
          automatic logic [DATA_W-1:0] e = exp_q.pop_front();
          automatic int w = wait_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, prdata, e);
          check({t, " R6 wait cycles"}, DATA_W'(wcnt), DATA_W'(w));
          wcnt = 0;
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] exp, input string tag);
    exp_q.push_back(exp);
    wait_q.push_back((a == ADDR_W'(REG_OFS)) ? 2 : 0);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk); #1;
    penable = 1'b1;
    @(negedge clk);
    while (!pready) @(negedge clk);
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(negedge clk);
    check("R5 write ready in first access cycle", DATA_W'(pready), 1);
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pwdata = '0;
  endtask

  localparam logic [ADDR_W-1:0] A_REG = ADDR_W'(REG_OFS);

  initial begin
    idle(3);
    por_rst = 1'b0; sys_rst = 1'b0;
    idle(2);
    bus_read(A_REG, 32'h0, "R3 reset state");

    // Enable with pin low: no event
    bus_write(A_REG, 32'h100);
    bus_read(A_REG, 32'h100, "R10 enable with pin low / R4");
    bus_write(A_REG, 32'hFFFF_FFFF);
    bus_read(A_REG, 32'h100, "R4 R2 only bit 8 writable");

    // Pin edge while enabled
    wake_pin = 1'b1;
    idle(5);
    bus_read(A_REG, 32'h101, "R8 pin edge sets wake flag");

    clr_wake = 1'b1; idle(1); clr_wake = 1'b0;
    bus_read(A_REG, 32'h100, "R12 clear wake flag");

    // Enable while pin already high
    bus_write(A_REG, 32'h0);
    bus_read(A_REG, 32'h0, "R4 enable cleared");
    bus_write(A_REG, 32'h100);
    bus_read(A_REG, 32'h101, "R10 enable while pin high");

    // Disabled pin ignores edges
    clr_wake = 1'b1; idle(1); clr_wake = 1'b0;
    bus_write(A_REG, 32'h0);
    wake_pin = 1'b0; idle(4);
    wake_pin = 1'b1; idle(5);
    bus_read(A_REG, 32'h0, "R8 disabled pin ignored");

    rtc_alarm = 1'b1; idle(1); rtc_alarm = 1'b0;
    bus_read(A_REG, 32'h1, "R9 alarm sets wake flag");

    stby_exit = 1'b1; idle(1); stby_exit = 1'b0;
    bus_read(A_REG, 32'h3, "R11 standby flag set");

    // Clear both, set wake in the same cycle
    clr_wake = 1'b1; clr_stby = 1'b1; rtc_alarm = 1'b1;
    idle(1);
    clr_wake = 1'b0; clr_stby = 1'b0; rtc_alarm = 1'b0;
    bus_read(A_REG, 32'h1, "R12 set wins over clear");

    // Monitor output
    vmon_en = 1'b1; vmon_cmp = 1'b1; idle(2);
    bus_read(A_REG, 32'h5, "R7 monitor high");
    vmon_cmp = 1'b0; idle(2);
    bus_read(A_REG, 32'h1, "R7 monitor low");
    vmon_en = 1'b0; vmon_cmp = 1'b1; idle(2);
    bus_read(A_REG, 32'h1, "R7 monitor disabled");
    vmon_cmp = 1'b0;

    // System reset keeps flags
    bus_write(A_REG, 32'h100);
    stby_exit = 1'b1; idle(1); stby_exit = 1'b0;
    bus_read(A_REG, 32'h103, "R11 R2 full word");
    sys_rst = 1'b1; idle(2); sys_rst = 1'b0;
    idle(1);
    bus_read(A_REG, 32'h3, "R3 system reset keeps flags");

    // Other addresses
    bus_read(ADDR_W'(8), 32'h0, "R1 foreign read");
    bus_write(ADDR_W'(0), 32'h100);
    bus_read(A_REG, 32'h3, "R1 foreign write ignored");

    // Power-on reset clears all
    por_rst = 1'b1; idle(2); por_rst = 1'b0;
    idle(1);
    bus_read(A_REG, 32'h0, "R3 power-on reset clears all");

    idle(3);
    check("R6 all reads consumed", DATA_W'(exp_q.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule